// File: doc/BRIEF.md
# Serial-Parallel Column-Sum Multiplier

This block multiplies two unsigned `N`-bit operands and delivers the `2N`-bit product one bit per clock. It forms each column of the partial-product array in a single cycle, least significant column first. The multiplicand bits leave a shift register one per clock and pass down a chain of delay flops. Each delay flop is ANDed with one bit of the held multiplier. A ripple of full adders adds these terms, and each adder keeps its own registered carry for the next column. The chain's final sum bit enters the top of a result shift register. After `2N` such cycles the register holds the complete product.

The block is used as a simple command and response engine. A one-cycle `start` pulse, given while the block is idle or finished, makes it capture both operands on the following clock. It then runs `2N` column cycles and raises `stop`. The product stays on `prod` until the next operation loads or reset is applied. Operands are sampled only on the load clock, so the driver may change them freely while the block is running.

Top module: `serpar_mult`

## Requirements
- R1: While `rst_n` is low and after its release, with no start given, `prod` is all zeros and `stop` is 0.
- R2: When `stop` is high, `prod` equals the unsigned product of the `op_a` and `op_b` values that were captured on the load clock.
- R3: If `start` is sampled high at clock edge E while the block is idle or finished, then `stop` is low after edges E through E+2N and goes high after edge E+2N+1 (one load clock followed by 2N column clocks).
- R4: `start` has no effect while an operation is loading or computing: the product and the timing of `stop` are those of the operation already under way.
- R5: While `stop` is high and `start` is low, `prod` and `stop` hold their values whatever `op_a` and `op_b` do.
- R6: A `start` accepted while finished drops `stop` after the sampling edge, and the load clock clears `prod` to zero.
- R7: `op_a` and `op_b` are sampled only on the load clock (the edge after `start` is sampled). Later changes to them do not alter the result.
- R8: The per-column carry flops and the multiplicand delay flops are cleared on every load. Left-over state from an earlier operation, such as all-ones times all-ones, has no effect on the next product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | N | Multiplicand, streamed out LSB first |
| op_b | input | N | Multiplier, held in parallel for the whole run |
| start | input | 1 | Request a new multiply; honoured only when idle or finished |
| prod | output | 2N | Product register, valid while `stop` is high |
| stop | output | 1 | High from the cycle after the last column until the next start |

## Verification
The bench builds two instances side by side, one with `N` = 8 and one with `N` = 32. The 8-bit lane drives many random operand pairs through short 16-column runs. The 32-bit lane reaches the 64-column schedule, full-width carries across long ripple chains, and products whose top bits depend on carries that persist over many columns. Both lanes apply the corner operands 0, 1 and all ones in sequences that leave maximal carry state before a zero operand.

// File: rtl/serpar_mult_pkg.sv
package serpar_mult_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LOAD = 2'b01,
    ST_CALC = 2'b10,
    ST_DONE = 2'b11
  } mul_state_t;

  typedef struct packed {
    logic carry;
    logic sum;
  } fa_out_t;

  // one-bit full adder: three inputs of equal weight
  function automatic fa_out_t full_add(input logic x, input logic y, input logic z);
    fa_out_t r;
    r.sum   = x ^ y ^ z;
    r.carry = (x & y) | (z & (x ^ y));
    return r;
  endfunction

endpackage

// File: rtl/serpar_mult_ctrl.sv
module serpar_mult_ctrl
  import serpar_mult_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic shift,
  output logic stop,
  output logic last
);
  localparam int CW = (PW > 1) ? $clog2(PW) : 1;

  mul_state_t st_q;
  logic [CW-1:0] cnt_q;

  assign last  = (cnt_q == CW'(PW - 1));
  assign load  = (st_q == ST_LOAD);
  assign shift = (st_q == ST_CALC);
  assign stop  = (st_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) st_q <= ST_LOAD;
        ST_LOAD: begin
          st_q  <= ST_CALC;
          cnt_q <= '0;
        end
        ST_CALC: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) st_q <= ST_DONE;
        end
        ST_DONE: if (start) st_q <= ST_LOAD;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && last) |=> stop);
  a_r4_run_uninterrupted: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !last) |=> shift);
  a_r6_load_then_first_column: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (shift && !last));
  a_r3_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load, shift, stop}));

endmodule

// File: rtl/serpar_mult_opa.sv
module serpar_mult_opa #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [N-1:0] din,
  output logic         bit_out,
  output logic         empty
);
  logic [N-1:0] q;

  assign bit_out = q[0];
  assign empty   = (q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {1'b0, q[N-1:1]};
  end

  a_r7_a_only_changes_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(q));

endmodule

// File: rtl/serpar_mult_column.sv
module serpar_mult_column
  import serpar_mult_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [N-1:0] b_in,
  input  logic         a_bit,
  output logic         col_bit
);
  logic [N-1:0] b_q;
  logic [N-1:1] dly_q;    // dly_q[j]: multiplicand bit from j columns ago
  logic [N-1:1] cy_q;     // registered carry of adder j
  logic [N-1:0] pp;       // partial products of the current column
  logic [N-1:0] run;      // running column sum along the ripple
  logic [N-1:1] cy_d;

  assign pp[0]  = b_q[0] & a_bit;
  assign run[0] = pp[0];

  for (genvar j = 1; j < N; j++) begin : g_stage
    fa_out_t fa;
    assign pp[j]   = b_q[j] & dly_q[j];
    assign fa      = full_add(run[j-1], pp[j], cy_q[j]);
    assign run[j]  = fa.sum;
    assign cy_d[j] = fa.carry;
  end

  assign col_bit = run[N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_q <= '0;
    else if (load) b_q <= b_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      cy_q  <= '0;
    end else if (load) begin
      dly_q <= '0;
      cy_q  <= '0;
    end else if (shift) begin
      if (N > 2) dly_q <= {dly_q[N-2:1], a_bit};
      else       dly_q <= a_bit;
      cy_q <= cy_d;
    end
  end

  a_r8_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (dly_q == '0 && cy_q == '0));
  a_r7_b_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(b_q));

endmodule

// File: rtl/serpar_mult_result.sv
module serpar_mult_result #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          bit_in,
  output logic [PW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= '0;
    else if (shift) q <= {bit_in, q[PW-1:1]};
  end

  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(q));
  a_r6_cleared_by_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == '0));

endmodule

// File: rtl/serpar_mult.sv
module serpar_mult #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  input  logic           start,
  output logic [2*N-1:0] prod,
  output logic           stop
);
  localparam int PW = 2 * N;

  logic ld_w, sh_w, last_w;
  logic a_bit_w, a_empty_w, col_bit_w;

  serpar_mult_ctrl #(.PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(ld_w), .shift(sh_w), .stop(stop), .last(last_w)
  );

  serpar_mult_opa #(.N(N)) u_opa (
    .clk(clk), .rst_n(rst_n), .load(ld_w), .shift(sh_w),
    .din(op_a), .bit_out(a_bit_w), .empty(a_empty_w)
  );

  serpar_mult_column #(.N(N)) u_col (
    .clk(clk), .rst_n(rst_n), .load(ld_w), .shift(sh_w),
    .b_in(op_b), .a_bit(a_bit_w), .col_bit(col_bit_w)
  );

  serpar_mult_result #(.PW(PW)) u_res (
    .clk(clk), .rst_n(rst_n), .load(ld_w), .shift(sh_w),
    .bit_in(col_bit_w), .q(prod)
  );

  // R2: the multiplicand is fully drained well before the final column
  a_r2_a_drained_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_w && last_w) |-> a_empty_w);
  a_r1_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_w && !sh_w && !stop) |-> (prod == '0));

endmodule

// File: tb/serpar_mult_tb_top.sv
`timescale 1ns/1ps

module serpar_mult_tb_lane #(
  parameter int N    = 8,
  parameter int OPS  = 30,
  parameter int SEED = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_chk,
  output int   n_bad
);
  logic [N-1:0]   a_in, b_in;
  logic           start;
  logic [2*N-1:0] prod;
  logic           stop;

  serpar_mult #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(a_in), .op_b(b_in),
    .start(start), .prod(prod), .stop(stop)
  );

  // shift-and-add reference, written independently of the column datapath
  function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [2*N-1:0] acc = '0;
    for (int i = 0; i < N; i++)
      if (b[i]) acc = acc + ({{N{1'b0}}, a} << i);
    return acc;
  endfunction

  function automatic logic [N-1:0] rnd();
    logic [63:0] r = {$urandom, $urandom};
    return r[N-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL N=%0d %s: actual %0h expected %0h", N, req, got, exp);
    end
  endtask

  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit poke);
    logic [2*N-1:0] exp = ref_mul(a, b);
    logic [2*N-1:0] held;
    @(negedge clk); a_in = a; b_in = b; start = 1'b1;
    @(negedge clk); start = 1'b0;                       // edge E sampled start
    check(stop == 1'b0, "R6 stop drops after start", 64'(stop), 64'd0);
    if (poke) start = 1'b1;                             // R4: start during load
    @(negedge clk);                                     // edge E+1: load
    check(prod == '0, "R6 prod cleared by load", 64'(prod), 64'd0);
    if (poke) begin                                     // R7: scramble inputs
      a_in = ~a; b_in = rnd(); start = 1'b1;
    end
    repeat (2*N - 1) begin
      @(negedge clk); start = 1'b0;
    end                                                 // edges up to E+2N
    check(stop == 1'b0, "R3 stop low before final column", 64'(stop), 64'd0);
    @(negedge clk);                                     // edge E+2N+1
    check(stop == 1'b1, "R3 stop after 2N columns", 64'(stop), 64'd1);
    check(prod == exp, poke ? "R2 R4 R7 product" : "R2 product", 64'(prod), 64'(exp));
    held = prod;
    repeat (3) begin
      a_in = rnd(); b_in = rnd();
      @(negedge clk);
      check(prod == held && stop, "R5 result held", 64'(prod), 64'(held));
    end
  endtask

  initial begin
    logic [N-1:0] ones = '1;
    logic [N-1:0] one  = N'(1);
    done = 1'b0; n_chk = 0; n_bad = 0;
    a_in = '0; b_in = '0; start = 1'b0;
    void'($urandom(SEED));
    @(negedge clk);
    check(prod == '0 && !stop, "R1 in reset", 64'(prod), 64'd0);
    wait (rst_n);
    repeat (2) @(negedge clk);
    check(prod == '0 && !stop, "R1 after reset", 64'(prod), 64'd0);
    run_op('0, '0, 1'b0);
    run_op(one, one, 1'b0);
    run_op(ones, ones, 1'b0);
    run_op('0, ones, 1'b0);        // R8: follows maximal carry state
    run_op(ones, ones, 1'b1);
    run_op(ones, '0, 1'b0);        // R8
    run_op(one, ones, 1'b0);
    run_op(ones, one, 1'b1);
    for (int k = 0; k < OPS; k++) run_op(rnd(), rnd(), k[0]);
    done = 1'b1;
  end
endmodule

module serpar_mult_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic d8, d32;
  int c8, b8, c32, b32;

  serpar_mult_tb_lane #(.N(8),  .OPS(40), .SEED(11)) lane8_i  (
    .clk(clk), .rst_n(rst_n), .done(d8),  .n_chk(c8),  .n_bad(b8));
  serpar_mult_tb_lane #(.N(32), .OPS(25), .SEED(23)) lane32_i (
    .clk(clk), .rst_n(rst_n), .done(d32), .n_chk(c32), .n_bad(b32));

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int cyc = 0;
    int tot, bad;
    bit hung;
    while (!(d8 === 1'b1 && d32 === 1'b1) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    hung = !(d8 === 1'b1 && d32 === 1'b1);
    tot = c8 + c32;
    bad = b8 + b32;
    if (hung) begin
      tot++; bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", tot, bad);
    $finish;
  end
endmodule